// File: doc/BRIEF.md
# Configurable Registered Buffer with Parity

This block is the clocked address and command register that sits on a memory module between the controller and the memory devices. On every rising clock edge it captures a data word and drives it out as registered outputs. Two strap inputs select one of two topologies. In the wide topology every input bit drives one output. In the split topology only the low data bits are used, and each one drives two outputs (an A copy and a B copy). The straps are sampled only while reset is held. In the split topology the straps also say whether this device is the first or the second register of a cascaded pair.

Clock-enable, termination-enable and chip-select each have a dedicated input and a dedicated registered output. Two active-low chip selects gate the data path. While neither is asserted, the data outputs keep their last value.

The block checks even parity. The count of ones across the active data bits plus a parity bit must be even. A failure is reported on an active-low error flag that is only ever pulled low. A partial-parity output and a partial-parity input let two devices share one check. The first device passes its partial result forward. The second device combines that result with its own registered data and raises the flag.

Top module: `regbuf_parity`

## Requirements
- R1: The straps `cfg` are sampled on rising edges while `rst_n` is low, and the topology is held until the next reset. The encodings are 2'b00 or 2'b10 for the wide topology, 2'b01 for the split first device and 2'b11 for the split second device. A change of `cfg` while `rst_n` is high has no effect on any output.
- R2: In the wide topology, a selected rising edge loads `q_a` with `d_in`, and `q_b` stays 0.
- R3: In either split topology, a selected rising edge loads both `q_a[13:0]` and `q_b` with `d_in[13:0]`, and `q_a[24:14]` stays 0.
- R4: An edge is selected when `dcs_n` or `csr_n` is low (both active-low). At an edge with both high, `q_a` and `q_b` keep their values. In the wide topology and the first-device topology, `err_n` and `ppo` also keep their values.
- R5: On every rising edge out of reset, `cke_q`, `odt_q` and `cs_q` take `cke_in`, `odt_in` and `dcs_n`, whether or not the edge is selected.
- R6: In the wide topology, a selected edge sets `err_n` to 0 when the number of ones in `d_in` plus `par_in` is odd, and to 1 when it is even.
- R7: In the split first-device topology, a selected edge sets `ppo` to the XOR of `d_in[13:0]` and `par_in`, and `err_n` stays 1.
- R8: In the wide topology, a selected edge sets `ppo` to 1 exactly when the parity sum of R6 is odd.
- R9: While `rst_n` is low, all registered outputs are 0, `err_n` is 1 and `ppo` is 0.
- R10: In the split second-device topology, at every edge that follows a selected edge, `err_n` becomes 0 and `ppo` becomes 1 when the XOR of `ppi` with the parity of the `d_in[13:0]` word captured at the previous edge is 1. They become `err_n` 1 and `ppo` 0 when that XOR is 0. At other edges both hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; straps are sampled while it is low |
| cfg | input | 2 | Topology straps |
| d_in | input | 25 | Data word |
| cke_in | input | 1 | Clock-enable input |
| odt_in | input | 1 | Termination-enable input |
| dcs_n | input | 1 | Chip select, active low; also registered to `cs_q` |
| csr_n | input | 1 | Second chip select, active low |
| par_in | input | 1 | Parity bit from the controller |
| ppi | input | 1 | Partial parity from the first device of a pair |
| q_a | output | 25 | Registered data, A copy |
| q_b | output | 14 | Registered data, B copy (split topologies only) |
| cke_q | output | 1 | Registered clock-enable |
| odt_q | output | 1 | Registered termination-enable |
| cs_q | output | 1 | Registered chip select |
| ppo | output | 1 | Registered partial-parity or parity-failure result |
| err_n | output | 1 | Active-low parity error flag (1 = released) |

## Verification
The bench runs every strap encoding, including the spare one. It flips the straps in the middle of a run. A design that re-read them would change its topology and corrupt `q_b` and the parity outputs. It drives all-ones and all-zero words around the parity boundary, where an odd/even inversion or a parity sum that leaves out `par_in` shows up at once. It leaves both chip selects high for runs of edges. A design that gated the dedicated outputs, or let the data move, would diverge from the model. The second-device case checks that the cascade result lags the captured word by one edge and pairs `ppi` with that earlier word rather than the current one.

// File: rtl/regbuf_parity.sv
`timescale 1ns/1ps
module regbuf_parity #(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg,
  input  logic [WIDE_W-1:0]   d_in,
  input  logic                cke_in,
  input  logic                odt_in,
  input  logic                dcs_n,
  input  logic                csr_n,
  input  logic                par_in,
  input  logic                ppi,
  output logic [WIDE_W-1:0]   q_a,
  output logic [NARROW_W-1:0] q_b,
  output logic                cke_q,
  output logic                odt_q,
  output logic                cs_q,
  output logic                ppo,
  output logic                err_n
);
  localparam int PAD_W = WIDE_W - NARROW_W;
  localparam logic [1:0] M_ONE = 2'd0, M_A = 2'd1, M_B = 2'd2;

  logic [1:0] mode_q;
  logic       cap_q, npar_q;

  wire sel       = ~dcs_n | ~csr_n;
  wire wide_bad  = ^{d_in, par_in};
  wire narrow_p  = ^d_in[NARROW_W-1:0];
  wire [WIDE_W-1:0] split_word = {{PAD_W{1'b0}}, d_in[NARROW_W-1:0]};

  always_ff @(posedge clk)
    if (!rst_n)
      mode_q <= (cfg == 2'b01) ? M_A : (cfg == 2'b11) ? M_B : M_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_a    <= '0;
      q_b    <= '0;
      cke_q  <= 1'b0;
      odt_q  <= 1'b0;
      cs_q   <= 1'b0;
      ppo    <= 1'b0;
      err_n  <= 1'b1;
      cap_q  <= 1'b0;
      npar_q <= 1'b0;
    end else begin
      cke_q <= cke_in;
      odt_q <= odt_in;
      cs_q  <= dcs_n;
      case (mode_q)
        M_A: if (sel) begin
          q_a   <= split_word;
          q_b   <= d_in[NARROW_W-1:0];
          ppo   <= narrow_p ^ par_in;
          err_n <= 1'b1;
        end
        M_B: begin
          if (cap_q) begin
            ppo   <= npar_q ^ ppi;
            err_n <= ~(npar_q ^ ppi);
          end
          if (sel) begin
            q_a    <= split_word;
            q_b    <= d_in[NARROW_W-1:0];
            npar_q <= narrow_p;
          end
          cap_q <= sel;
        end
        default: if (sel) begin
          q_a   <= d_in;
          q_b   <= '0;
          ppo   <= wide_bad;
          err_n <= ~wide_bad;
        end
      endcase
    end
  end
endmodule

// File: rtl/regbuf_parity_chk.sv
`timescale 1ns/1ps
module regbuf_parity_chk #(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode_q,
  input logic [WIDE_W-1:0]   d_in,
  input logic                cke_in,
  input logic                dcs_n,
  input logic                csr_n,
  input logic                par_in,
  input logic [WIDE_W-1:0]   q_a,
  input logic [NARROW_W-1:0] q_b,
  input logic                cke_q,
  input logic                cs_q,
  input logic                ppo,
  input logic                err_n
);
  wire desel = dcs_n & csr_n;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (q_a == '0 && q_b == '0 && err_n && !ppo && !cke_q && !cs_q)); // R9
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q)); // R1
  AST_WIDE_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> (q_b == '0)); // R2
  AST_SPLIT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd0) |-> (q_a[NARROW_W-1:0] == q_b && q_a[WIDE_W-1:NARROW_W] == '0)); // R3
  AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> ($stable(q_a) && $stable(q_b))); // R4
  AST_DEDICATED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cs_q == $past(dcs_n) && cke_q == $past(cke_in))); // R5
  AST_WIDE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && !desel) |=> (err_n == ~$past(^{d_in, par_in}))); // R6
  AST_FIRST_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1) |-> err_n); // R7
endmodule

bind regbuf_parity regbuf_parity_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .d_in(d_in), .cke_in(cke_in),
  .dcs_n(dcs_n), .csr_n(csr_n), .par_in(par_in), .q_a(q_a), .q_b(q_b),
  .cke_q(cke_q), .cs_q(cs_q), .ppo(ppo), .err_n(err_n));

// File: tb/regbuf_parity_tb_top.sv
`timescale 1ns/1ps
module regbuf_parity_tb_top;
  logic clk = 1'b0, rst_n = 1'b1;
  logic [1:0] cfg = 2'b00;
  logic [24:0] d_in = '0;
  logic cke_in = 0, odt_in = 0, dcs_n = 1, csr_n = 1, par_in = 0, ppi = 0;
  logic [24:0] q_a; logic [13:0] q_b;
  logic cke_q, odt_q, cs_q, ppo, err_n;

  regbuf_parity dut_i (.clk(clk), .rst_n(rst_n), .cfg(cfg), .d_in(d_in), .cke_in(cke_in),
    .odt_in(odt_in), .dcs_n(dcs_n), .csr_n(csr_n), .par_in(par_in), .ppi(ppi),
    .q_a(q_a), .q_b(q_b), .cke_q(cke_q), .odt_q(odt_q), .cs_q(cs_q), .ppo(ppo), .err_n(err_n));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_mode = 0;
  logic [24:0] e_qa; logic [13:0] e_qb;
  logic e_cke, e_odt, e_cs, e_ppo, e_errn, m_cap, m_par;

  always @(posedge clk) if (!rst_n) m_mode = (cfg == 2'b01) ? 1 : (cfg == 2'b11) ? 2 : 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_qa = '0; e_qb = '0; e_cke = 0; e_odt = 0; e_cs = 0;
      e_ppo = 0; e_errn = 1; m_cap = 0; m_par = 0;
    end else begin
      bit s; int ones;
      s = !dcs_n || !csr_n;
      e_cke = cke_in; e_odt = odt_in; e_cs = dcs_n;
      if (m_mode == 0) begin
        if (s) begin
          ones = $countones(d_in) + int'(par_in);
          e_qa = d_in; e_qb = '0; e_ppo = 1'(ones % 2); e_errn = !e_ppo;
        end
      end else begin
        if (m_mode == 2 && m_cap) begin
          e_ppo = 1'((int'(m_par) + int'(ppi)) % 2); e_errn = !e_ppo;
        end
        if (s) begin
          e_qa = {11'b0, d_in[13:0]}; e_qb = d_in[13:0];
          if (m_mode == 1) begin
            e_ppo = 1'(($countones(d_in[13:0]) + int'(par_in)) % 2); e_errn = 1;
          end else m_par = 1'($countones(d_in[13:0]) % 2);
        end
        if (m_mode == 2) m_cap = s;
      end
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  bit prev_desel = 0, flipped = 0;
  task automatic compare();
    string tq, tp;
    if (!rst_n) begin tq = "R9"; tp = "R9"; end
    else if (prev_desel) begin tq = "R4"; tp = (m_mode == 2) ? "R10" : "R4"; end
    else if (flipped) begin tq = "R1"; tp = "R1"; end
    else begin
      tq = (m_mode == 0) ? "R2" : "R3";
      tp = (m_mode == 0) ? "R6" : (m_mode == 1) ? "R7" : "R10";
    end
    check(tq, "q_a", 32'(q_a), 32'(e_qa));
    check(tq, "q_b", 32'(q_b), 32'(e_qb));
    check(rst_n ? "R5" : "R9", "cke_q", 32'(cke_q), 32'(e_cke));
    check(rst_n ? "R5" : "R9", "odt_q", 32'(odt_q), 32'(e_odt));
    check(rst_n ? "R5" : "R9", "cs_q", 32'(cs_q), 32'(e_cs));
    check(tp, "err_n", 32'(err_n), 32'(e_errn));
    check((tp == "R6") ? "R8" : tp, "ppo", 32'(ppo), 32'(e_ppo));
  endtask

  task automatic run_mode(logic [1:0] strap, int n);
    @(negedge clk);
    cfg = strap; rst_n = 0; flipped = 0; prev_desel = 0;
    for (int k = 0; k < 3; k++) begin @(negedge clk); compare(); end
    rst_n = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      if (i == n / 2) begin cfg = ~strap; flipped = 1; end
      case (i % 8)
        0: begin d_in = '1; par_in = 1; end
        1: begin d_in = '0; par_in = 1; end
        2: begin d_in = '1; par_in = 0; end
        default: begin d_in = 25'($urandom); par_in = 1'($urandom); end
      endcase
      ppi = 1'($urandom); cke_in = 1'($urandom); odt_in = 1'($urandom);
      dcs_n = 1'($urandom); csr_n = ($urandom % 4 != 0);
      if (i % 8 < 3) begin dcs_n = 0; csr_n = 1; end
      prev_desel = dcs_n && csr_n;
    end
  endtask

  initial begin
    #1 rst_n = 0;
    run_mode(2'b00, 400);
    run_mode(2'b01, 400);
    run_mode(2'b11, 400);
    run_mode(2'b10, 200);
    run_mode(2'b00, 50);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule